// File: doc/BRIEF.md
# Daughter Card Reference Clock Divider

This block can put a divided copy of the master clock on I/O pin 0 of one daughter-card bank. Software programs it through one 32-bit configuration word. The low seven bits hold a divisor. The bit just above them turns the clock output on. When that bit is set, the block takes pin 0 away from the general-purpose output logic, drives the pin as an output, and sends a square wave on it. When the bit is clear, pin 0 passes the general-purpose value and direction through unchanged.

The square wave is made by a counter that reloads every time it reaches the divisor, and a flip-flop that changes state on each reload. Each half period therefore lasts as many master-clock cycles as the divisor, and the duty cycle is exactly 50%. Any write to the word restarts the counter and forces the wave low, so a new divisor never produces a stretched or clipped pulse. Bits 31:8 of the word are reserved. The block stores only the low byte, and the read port returns zeros above it.

Top module: `refclk_div_top`

## Requirements
- R1: After a synchronous active-low reset, the stored byte is zero, the read port returns 0, and pin 0 follows the general-purpose output and direction inputs.
- R2: One cycle after a write, the read port returns bits 7:0 of the written word and zero in bits 31:8.
- R3: While bit 7 of the stored word is 0, the pin-0 drive equals the general-purpose output and the pin-0 enable equals the general-purpose direction, with no clock delay.
- R4: While bit 7 is 1, the pin-0 enable is 1 whatever the general-purpose direction is, and the pin-0 drive does not depend on the general-purpose output.
- R5: With bit 7 set and divisor D in bits 6:0 (D from 1 to 127), the pin-0 drive is low right after the write edge. After k further clock edges it equals floor(k/D) mod 2, so each half period is D cycles and the period is 2·D.
- R6: A divisor of 0 with bit 7 set behaves exactly like a divisor of 1: the drive toggles on every clock edge.
- R7: A write while the clock is running restarts the sequence. The drive is low in the cycle after the write edge and follows R5 from that edge onward.
- R8: Bits 31:8 of a written word have no effect on the read port or on the pin-0 waveform.
- R9: Clearing bit 7 returns pin 0 to general-purpose use one cycle after the write edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Master clock |
| rst_ni | input | 1 | Synchronous active-low reset |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_wdata_i | input | 32 | Configuration write data (bit 7 enable, bits 6:0 divisor) |
| cfg_rdata_o | output | 32 | Stored configuration byte, zero-extended |
| gpio_out_i | input | 1 | General-purpose output value for pin 0 |
| gpio_oe_i | input | 1 | General-purpose direction for pin 0 (1 = output) |
| pin0_out_o | output | 1 | Drive value for pin 0 |
| pin0_oe_o | output | 1 | Output enable for pin 0 |

## Verification
A write is captured at the clock edge on which the strobe is high. The read port and the pin-0 selection change right after that edge, and the bench samples them at the following falling edge. The general-purpose inputs reach the pin through combinational logic only, so the bench changes them at a falling edge and checks the pin a moment later in the same cycle. For the divided clock, the bench counts k clock edges after the write edge and compares the drive at each falling edge with floor(k/D) mod 2, using an effective divisor of 1 for a zero divisor. The general-purpose output is toggled throughout, so any leakage of it into the drive shows up as a mismatch.

// File: rtl/refclk_div_pkg.sv
// Package: refclk_div_pkg
// Holds the divisor width and the stored configuration type shared by the
// register, the toggle generator and the pin multiplexer.
package refclk_div_pkg;

    localparam int unsigned REFDIV_W = 7;

    typedef struct packed {
        logic                enable;
        logic [REFDIV_W-1:0] divisor;
    } refclk_cfg_t;

endpackage

// File: rtl/refclk_cfg_reg.sv
// Module: refclk_cfg_reg
// Stores the enable bit and divisor from a configuration write and returns
// them zero-extended on the read port. Reserved bits are dropped here.
// Assumes DATA_W is larger than the divisor width plus one.
module refclk_cfg_reg
    import refclk_div_pkg::*;
#(
    parameter int unsigned DATA_W = 32
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              we_i,
    input  logic [DATA_W-1:0] wdata_i,
    output refclk_cfg_t       cfg_o,
    output logic [DATA_W-1:0] rdata_o
);

    localparam int unsigned EN_BIT  = REFDIV_W;
    localparam int unsigned CFG_W   = REFDIV_W + 1;
    localparam int unsigned RSVD_W  = DATA_W - CFG_W;

    refclk_cfg_t cfg_q;

    // Capture the low byte of a write; clear on reset.
    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            cfg_q <= '0;
        end else if (we_i) begin
            cfg_q.enable  <= wdata_i[EN_BIT];
            cfg_q.divisor <= wdata_i[REFDIV_W-1:0];
        end
    end

    // Zero-extend the stored byte for the read port.
    always_comb begin
        rdata_o = {{RSVD_W{1'b0}}, cfg_q};
    end

    assign cfg_o = cfg_q;

endmodule

// File: rtl/refclk_toggle_gen.sv
// Module: refclk_toggle_gen
// Divides the master clock by twice the effective divisor with a reload
// counter and a toggle flip-flop. A zero divisor counts as one. The restart
// input (a configuration write) and a clear enable hold the counter at zero
// and the output low.
module refclk_toggle_gen
    import refclk_div_pkg::*;
(
    input  logic        clk_i,
    input  logic        rst_ni,
    input  logic        restart_i,
    input  refclk_cfg_t cfg_i,
    output logic        refclk_o
);

    logic [REFDIV_W-1:0] eff_div;
    logic [REFDIV_W-1:0] cnt_q;
    logic                tick;
    logic                wave_q;

    // Map a zero divisor to one and flag the last count of a half period.
    always_comb begin
        eff_div = (cfg_i.divisor == '0) ? REFDIV_W'(1) : cfg_i.divisor;
        tick    = (cnt_q == eff_div - REFDIV_W'(1));
    end

    // Count one half period, then reload and flip the output.
    always_ff @(posedge clk_i) begin
        if (!rst_ni || restart_i || !cfg_i.enable) begin
            cnt_q  <= '0;
            wave_q <= 1'b0;
        end else if (tick) begin
            cnt_q  <= '0;
            wave_q <= ~wave_q;
        end else begin
            cnt_q  <= cnt_q + REFDIV_W'(1);
        end
    end

    assign refclk_o = wave_q;

endmodule

// File: rtl/refclk_pin_mux.sv
// Module: refclk_pin_mux
// Chooses between the general-purpose output and the divided clock for
// pin 0. When the clock is enabled the pin is forced to output. Purely
// combinational.
module refclk_pin_mux (
    input  logic enable_i,
    input  logic refclk_i,
    input  logic gpio_out_i,
    input  logic gpio_oe_i,
    output logic pin_out_o,
    output logic pin_oe_o
);

    // Override value and direction while the clock output is on.
    always_comb begin
        if (enable_i) begin
            pin_out_o = refclk_i;
            pin_oe_o  = 1'b1;
        end else begin
            pin_out_o = gpio_out_i;
            pin_oe_o  = gpio_oe_i;
        end
    end

endmodule

// File: rtl/refclk_div_top.sv
// Module: refclk_div_top
// Daughter-card pin-0 reference clock divider: a configuration register,
// a toggle divider and a pin-0 override multiplexer.
// Assumes one clock domain and a synchronous active-low reset.
module refclk_div_top
    import refclk_div_pkg::*;
#(
    parameter int unsigned DATA_W = 32
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              cfg_we_i,
    input  logic [DATA_W-1:0] cfg_wdata_i,
    output logic [DATA_W-1:0] cfg_rdata_o,
    input  logic              gpio_out_i,
    input  logic              gpio_oe_i,
    output logic              pin0_out_o,
    output logic              pin0_oe_o
);

    refclk_cfg_t cfg;
    logic        refclk;

    refclk_cfg_reg #(
        .DATA_W (DATA_W)
    ) u_cfg (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .we_i    (cfg_we_i),
        .wdata_i (cfg_wdata_i),
        .cfg_o   (cfg),
        .rdata_o (cfg_rdata_o)
    );

    refclk_toggle_gen u_gen (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .restart_i (cfg_we_i),
        .cfg_i     (cfg),
        .refclk_o  (refclk)
    );

    refclk_pin_mux u_mux (
        .enable_i   (cfg.enable),
        .refclk_i   (refclk),
        .gpio_out_i (gpio_out_i),
        .gpio_oe_i  (gpio_oe_i),
        .pin_out_o  (pin0_out_o),
        .pin_oe_o   (pin0_oe_o)
    );

endmodule

// File: rtl/refclk_div_chk.sv
// Module: refclk_div_chk
// Property checker for refclk_div_top, attached with bind. It watches only
// the top-level ports. Assumes the enable bit sits at position 7 of the word.
module refclk_div_chk #(
    parameter int unsigned DATA_W = 32
) (
    input logic              clk_i,
    input logic              rst_ni,
    input logic              cfg_we_i,
    input logic [DATA_W-1:0] cfg_wdata_i,
    input logic [DATA_W-1:0] cfg_rdata_o,
    input logic              gpio_out_i,
    input logic              gpio_oe_i,
    input logic              pin0_out_o,
    input logic              pin0_oe_o
);

    AST_RESET_CLEARS: assert property (@(posedge clk_i)
        $rose(rst_ni) |-> (cfg_rdata_o == '0)); // R1

    AST_WRITE_READBACK: assert property (@(posedge clk_i) disable iff (!rst_ni)
        cfg_we_i |=> (cfg_rdata_o == {{(DATA_W-8){1'b0}}, $past(cfg_wdata_i[7:0])})); // R2

    AST_GPIO_PASS: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !cfg_rdata_o[7] |-> (pin0_out_o == gpio_out_i && pin0_oe_o == gpio_oe_i)); // R3

    AST_OE_FORCED: assert property (@(posedge clk_i) disable iff (!rst_ni)
        cfg_rdata_o[7] |-> pin0_oe_o); // R4

    AST_FAST_TOGGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (cfg_rdata_o[7] && cfg_rdata_o[6:0] <= 7'd1 && !cfg_we_i)
        |=> (pin0_out_o != $past(pin0_out_o))); // R6

    AST_RESTART_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (cfg_we_i && cfg_wdata_i[7]) |=> !pin0_out_o); // R7

endmodule

bind refclk_div_top refclk_div_chk #(
    .DATA_W (DATA_W)
) u_chk (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .cfg_we_i    (cfg_we_i),
    .cfg_wdata_i (cfg_wdata_i),
    .cfg_rdata_o (cfg_rdata_o),
    .gpio_out_i  (gpio_out_i),
    .gpio_oe_i   (gpio_oe_i),
    .pin0_out_o  (pin0_out_o),
    .pin0_oe_o   (pin0_oe_o)
);

// File: tb/refclk_div_top_tb.sv
// Bench for refclk_div_top: walks a table of configuration words, then runs
// directed checks for reset, restart and reset while running.
module refclk_div_top_tb;

    localparam int unsigned DATA_W = 32;
    localparam int unsigned NVEC   = 8;
    localparam int unsigned WDOG   = 200000;

    typedef struct packed {
        logic [31:0] word;
        logic        gout;
        logic        goe;
    } vec_t;

    localparam vec_t VECS [NVEC] = '{
        '{32'h0000_0005, 1'b1, 1'b1},  // disabled, R3
        '{32'h0000_0003, 1'b0, 1'b0},  // disabled, R3
        '{32'h0000_0083, 1'b1, 1'b0},  // D=3, R5
        '{32'h0000_0081, 1'b0, 1'b0},  // D=1, R5
        '{32'h0000_0080, 1'b1, 1'b0},  // D=0 -> 1, R6
        '{32'hFFFF_FF82, 1'b0, 1'b0},  // reserved set, R8
        '{32'h0000_00FF, 1'b1, 1'b0},  // D=127, R5
        '{32'h0000_0002, 1'b1, 1'b1}   // back to GPIO, R9
    };

    logic              clk;
    logic              rst_n;
    logic              we;
    logic [DATA_W-1:0] wdata;
    logic [DATA_W-1:0] rdata;
    logic              gout;
    logic              goe;
    logic              pout;
    logic              poe;

    int checks   = 0;
    int failures = 0;
    bit done     = 0;

    refclk_div_top #(.DATA_W(DATA_W)) u_dut (
        .clk_i       (clk),
        .rst_ni      (rst_n),
        .cfg_we_i    (we),
        .cfg_wdata_i (wdata),
        .cfg_rdata_o (rdata),
        .gpio_out_i  (gout),
        .gpio_oe_i   (goe),
        .pin0_out_o  (pout),
        .pin0_oe_o   (poe)
    );

    initial clk = 1'b0;
    always #2 clk = ~clk;

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
        end
    endtask

    task automatic write_cfg(input logic [31:0] w);
        we    = 1'b1;
        wdata = w;
        @(posedge clk);
        @(negedge clk);
        we    = 1'b0;
        wdata = '0;
    endtask

    // Follow the wave for ncyc edges after the write edge; one check per run.
    task automatic run_wave(input string req, input int eff, input int ncyc);
        logic [31:0] bad_act;
        logic [31:0] bad_exp;
        bit          bad;
        bad = 0;
        bad_act = '0;
        bad_exp = '0;
        for (int k = 1; k <= ncyc; k++) begin
            @(posedge clk);
            @(negedge clk);
            gout = ~gout;
            #1;
            if (!bad && (pout !== 1'((k / eff) % 2) || poe !== 1'b1)) begin
                bad     = 1;
                bad_act = {30'd0, poe, pout};
                bad_exp = {30'd0, 1'b1, 1'((k / eff) % 2)};
            end
        end
        check(req, bad_act, bad_exp);
    endtask

    initial begin
        #(4 * WDOG);
        if (!done) begin
            failures++;
            checks++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0;
        we    = 1'b0;
        wdata = '0;
        gout  = 1'b1;
        goe   = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R1: reset state
        check("R1 rdata", rdata, 32'd0);
        check("R1 pin", {30'd0, poe, pout}, {30'd0, goe, gout});

        // Table walk
        for (int i = 0; i < NVEC; i++) begin
            int eff;
            gout = VECS[i].gout;
            goe  = VECS[i].goe;
            write_cfg(VECS[i].word);
            #1;
            check("R2 R8 readback", rdata, {24'd0, VECS[i].word[7:0]});
            if (VECS[i].word[7]) begin
                eff = (VECS[i].word[6:0] == 7'd0) ? 1 : int'(VECS[i].word[6:0]);
                check("R7 low after write", {31'd0, pout}, 32'd0);
                run_wave(VECS[i].word[6:0] == 7'd0 ? "R6 zero divisor" :
                         (VECS[i].word[31:8] != 0 ? "R8 reserved" : "R5 R4 wave"),
                         eff, 4 * eff + 2);
            end else begin
                check("R3 R9 gpio pass", {30'd0, poe, pout}, {30'd0, goe, gout});
                gout = ~gout;
                goe  = ~goe;
                #1;
                check("R3 gpio comb", {30'd0, poe, pout}, {30'd0, goe, gout});
            end
        end

        // R7: restart mid-high with the same divisor
        write_cfg(32'h0000_0084);
        repeat (5) begin
            @(posedge clk);
            @(negedge clk);
        end
        #1;
        check("R5 high at k=5", {31'd0, pout}, 32'd1);
        write_cfg(32'h0000_0084);
        #1;
        check("R7 restart low", {31'd0, pout}, 32'd0);
        run_wave("R7 restart wave", 4, 12);

        // R1: reset while running
        @(negedge clk);
        rst_n = 1'b0;
        @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        goe   = 1'b0;
        gout  = 1'b1;
        #1;
        check("R1 reset rdata", rdata, 32'd0);
        check("R1 reset pin", {30'd0, poe, pout}, {30'd0, 1'b0, 1'b1});

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule